// File: doc/BRIEF.md
# Receive Loss-of-Signal Monitor

This block sits behind a line receiver's clock and data recovery. It watches the recovered bipolar bit stream, one bit per enable pulse, and decides whether the line carries a live signal. It declares loss when a long unbroken run of zeros arrives. It also declares loss out of reset and holds it until a window of bits shows enough pulse density. While loss is declared, the data outputs are held low.

The block also chooses the clock that should drive the downstream jitter attenuator. With the line healthy, that is the recovered clock. During loss, it is an alternate reference clock if that clock is toggling, and otherwise the local oscillator pulled to its centre frequency. A small detector decides whether the alternate reference clock is toggling. It synchronises that clock into the system clock domain and times out when no edge is seen.

Top module: `lsm_monitor`

## Requirements
- R1: A bit is taken from `rx_pos`/`rx_neg` in each cycle where `bit_vld` is high. The bit is a zero when both rails are low. `los` rises at the clock edge that takes the 175th consecutive zero.
- R2: Any bit with a pulse on either rail restarts the zero run. A run of 174 zeros, then a one, then 174 more zeros leaves `los` low.
- R3: After reset `los` is 1, `alt_active` is 0 and `clk_src` is 2 (centred oscillator).
- R4: After each bit edge, `out_pos`, `out_neg` and `out_data` hold that bit's positive rail, negative rail and rail OR, each gated by the new `los`. All three are 0 whenever `los` is 1, and all three are 0 in cycles without `bit_vld`.
- R5: While `los` is 1, bits are grouped into windows of 128. The first window starts with the first bit after `los` rises or after reset. `los` clears at the edge that takes a window's 128th bit if that window held at least 16 ones and no run of 100 zeros. Exactly 16 ones, or a 99-zero run, is enough.
- R6: A window with 15 ones, or one that contains a run of 100 zeros, leaves `los` at 1, and a fresh window starts.
- R7: `alt_active` goes to 1 within 4 cycles of an `alt_ref` transition. It falls to 0 once 64 system cycles pass without a synchronised transition.
- R8: `clk_src` is 0 (recovered clock) when `los` is 0. During loss it is 1 (alternate reference) when `alt_active` is 1 and 2 (centred oscillator) otherwise. It is updated on the same edge as `los` and `alt_active`.
- R9: `clk_src` changes only when `los` changes, or when `alt_active` changes while `los` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | One recovered bit is present on the rails this cycle |
| rx_pos | input | 1 | Positive-rail pulse of the current bit |
| rx_neg | input | 1 | Negative-rail pulse of the current bit |
| alt_ref | input | 1 | Alternate reference clock, asynchronous |
| los | output | 1 | Loss of signal declared |
| out_pos | output | 1 | Gated positive-rail data |
| out_neg | output | 1 | Gated negative-rail data |
| out_data | output | 1 | Gated merged data (OR of rails) |
| clk_src | output | 2 | Attenuator clock source: 0 recovered, 1 alternate, 2 centred oscillator |
| alt_active | output | 1 | Alternate reference clock seen toggling |

## Verification
Data outputs, `los` and `clk_src` are all due one edge after the bit that moves them. The driver applies each bit on a falling edge and pushes the predicted result for it. The monitor pops that prediction on the following falling edge, after exactly one rising edge. `alt_active` settles up to four cycles after an `alt_ref` edge and up to about 67 cycles after the last one. Those checks therefore run only after idle gaps of 10 and 80 cycles, well past those windows.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    SRC_RECOVERED = 2'd0,
    SRC_ALT       = 2'd1,
    SRC_CENTRE    = 2'd2
  } clk_src_e;

  // A received bit is a zero when neither rail carries a pulse.
  function automatic logic bit_is_zero(input logic pos, input logic neg);
    return !(pos || neg);
  endfunction

  // Attenuator clock source from loss state and alternate-clock activity.
  function automatic clk_src_e pick_src(input logic lost, input logic alt_ok);
    if (!lost)  return SRC_RECOVERED;
    if (alt_ok) return SRC_ALT;
    return SRC_CENTRE;
  endfunction

endpackage

// File: rtl/lsm_zero_run.sv
module lsm_zero_run #(
  parameter int LIMIT = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic zero,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] run_len;

  // Pulse on the bit that completes the run.
  assign hit = bit_vld && zero && (run_len == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (bit_vld) begin
      if (!zero)                       run_len <= '0;
      else if (run_len != CW'(LIMIT))  run_len <= run_len + 1'b1;
    end
  end

  a_r1_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= CW'(LIMIT));

  a_r2_one_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !zero) |=> (run_len == '0));

endmodule

// File: rtl/lsm_recovery_window.sv
module lsm_recovery_window #(
  parameter int WIN_BITS = 128,
  parameter int MIN_ONES = 16,
  parameter int WIN_RUN  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic bit_vld,
  input  logic zero,
  output logic pass,
  output logic win_end
);
  localparam int BW = $clog2(WIN_BITS + 1);
  localparam int RW = $clog2(WIN_RUN + 1);

  logic [BW-1:0] seen, ones, ones_nx;
  logic [RW-1:0] zrun;
  logic          broke, broke_nx, last;

  assign last     = (seen == BW'(WIN_BITS - 1));
  assign ones_nx  = ones + (zero ? BW'(0) : BW'(1));
  assign broke_nx = broke || (zero && (zrun == RW'(WIN_RUN - 1)));
  assign win_end  = armed && bit_vld && last;
  assign pass     = win_end && (ones_nx >= BW'(MIN_ONES)) && !broke_nx;

  always_ff @(posedge clk) begin
    if (!rst_n || !armed) begin
      seen  <= '0;
      ones  <= '0;
      zrun  <= '0;
      broke <= 1'b0;
    end else if (bit_vld) begin
      if (last) begin
        seen  <= '0;
        ones  <= '0;
        zrun  <= '0;
        broke <= 1'b0;
      end else begin
        seen  <= seen + 1'b1;
        ones  <= ones_nx;
        broke <= broke_nx;
        if (!zero)                        zrun <= '0;
        else if (zrun != RW'(WIN_RUN))    zrun <= zrun + 1'b1;
      end
    end
  end

  a_r5_ones_within_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= seen);

  a_r6_idle_when_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (seen == '0 && !broke));

endmodule

// File: rtl/lsm_alt_detect.sv
module lsm_alt_detect #(
  parameter int TIMEOUT = 64,
  parameter int SYNC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alt_ref,
  output logic active,
  output logic active_nx,
  output logic edge_seen
);
  localparam int IW = $clog2(TIMEOUT + 1);

  logic [SYNC:0]  sh;
  logic [IW-1:0]  idle, idle_nx;

  // Synchroniser chain plus one stage for edge detection.
  genvar g;
  generate
    for (g = 0; g <= SYNC; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk)
          if (!rst_n) sh[0] <= 1'b0; else sh[0] <= alt_ref;
      end else begin : g_next
        always_ff @(posedge clk)
          if (!rst_n) sh[g] <= 1'b0; else sh[g] <= sh[g-1];
      end
    end
  endgenerate

  assign edge_seen = sh[SYNC] ^ sh[SYNC-1];
  assign idle_nx   = edge_seen ? '0 :
                     (idle == IW'(TIMEOUT)) ? idle : idle + 1'b1;
  assign active_nx = edge_seen || (active && (idle_nx != IW'(TIMEOUT)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle   <= IW'(TIMEOUT);
      active <= 1'b0;
    end else begin
      idle   <= idle_nx;
      active <= active_nx;
    end
  end

  a_r7_edge_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> active);

  a_r7_timeout_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (idle == IW'(TIMEOUT)) |-> !active);

endmodule

// File: rtl/lsm_monitor.sv
module lsm_monitor #(
  parameter int ZERO_LIMIT  = 175,
  parameter int WIN_BITS    = 128,
  parameter int MIN_ONES    = 16,
  parameter int WIN_RUN     = 100,
  parameter int ALT_TIMEOUT = 64,
  parameter int ALT_SYNC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       rx_pos,
  input  logic       rx_neg,
  input  logic       alt_ref,
  output logic       los,
  output logic       out_pos,
  output logic       out_neg,
  output logic       out_data,
  output logic [1:0] clk_src,
  output logic       alt_active
);
  import lsm_pkg::*;

  logic     zero, run_hit, win_pass, win_end, los_nx, alt_nx, alt_edge;
  clk_src_e src_q;

  assign zero = bit_is_zero(rx_pos, rx_neg);

  lsm_zero_run #(.LIMIT(ZERO_LIMIT)) u_run (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .zero(zero), .hit(run_hit)
  );

  lsm_recovery_window #(.WIN_BITS(WIN_BITS), .MIN_ONES(MIN_ONES), .WIN_RUN(WIN_RUN)) u_win (
    .clk(clk), .rst_n(rst_n), .armed(los), .bit_vld(bit_vld), .zero(zero),
    .pass(win_pass), .win_end(win_end)
  );

  lsm_alt_detect #(.TIMEOUT(ALT_TIMEOUT), .SYNC(ALT_SYNC)) u_alt (
    .clk(clk), .rst_n(rst_n), .alt_ref(alt_ref),
    .active(alt_active), .active_nx(alt_nx), .edge_seen(alt_edge)
  );

  // Declaring loss takes priority over a passing window.
  assign los_nx = run_hit ? 1'b1 : (win_pass ? 1'b0 : los);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los      <= 1'b1;
      out_pos  <= 1'b0;
      out_neg  <= 1'b0;
      out_data <= 1'b0;
      src_q    <= SRC_CENTRE;
    end else begin
      los      <= los_nx;
      out_pos  <= bit_vld && rx_pos && !los_nx;
      out_neg  <= bit_vld && rx_neg && !los_nx;
      out_data <= bit_vld && !zero && !los_nx;
      src_q    <= pick_src(los_nx, alt_nx);
    end
  end

  assign clk_src = src_q;

  a_r3_lost_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (los && src_q == SRC_CENTRE));

  a_r4_quiet_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
    los |-> !(out_pos || out_neg || out_data));

  a_r1_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(run_hit));

  a_r5_fall_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(win_pass && win_end));

  a_r8_src_healthy: assert property (@(posedge clk) disable iff (!rst_n)
    !los |-> (src_q == SRC_RECOVERED));

  a_r8_src_lost: assert property (@(posedge clk) disable iff (!rst_n)
    los |-> (src_q == (alt_active ? SRC_ALT : SRC_CENTRE)));

  a_r9_src_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(los) && ($stable(alt_active) || !los)) |-> $stable(src_q));

endmodule

// File: tb/sim_lsm_monitor.sv
module sim_lsm_monitor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0, alt_ref = 1'b0;
  logic       los, out_pos, out_neg, out_data, alt_active;
  logic [1:0] clk_src;

  lsm_monitor u0 (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .alt_ref(alt_ref), .los(los), .out_pos(out_pos), .out_neg(out_neg),
    .out_data(out_data), .clk_src(clk_src), .alt_active(alt_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic       l, p, n, d;
    logic [1:0] s;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state, kept independently of the design.
  bit m_lost = 1;
  int m_run = 0, m_cnt = 0, m_ones = 0, m_wrun = 0;
  bit m_broke = 0, exp_alt = 0, alt_run = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] src_of(input bit lost, input bit alt);
    return !lost ? 2'd0 : (alt ? 2'd1 : 2'd2);
  endfunction

  task automatic model_reset();
    m_lost = 1; m_run = 0; m_cnt = 0; m_ones = 0; m_wrun = 0; m_broke = 0;
  endtask

  task automatic send_bit(input logic p, input logic n, input string tag);
    exp_t e;
    bit one;
    @(negedge clk);
    rx_pos = p; rx_neg = n; bit_vld = 1'b1;
    one = p | n;
    m_run = one ? 0 : ((m_run < 175) ? m_run + 1 : 175);
    if (!m_lost) begin
      if (m_run == 175) m_lost = 1;
    end else begin
      m_cnt += 1;
      if (one) begin m_ones += 1; m_wrun = 0; end
      else begin m_wrun += 1; if (m_wrun >= 100) m_broke = 1; end
      if (m_cnt == 128) begin
        if (m_ones >= 16 && !m_broke) m_lost = 0;
        m_cnt = 0; m_ones = 0; m_wrun = 0; m_broke = 0;
      end
    end
    e.l = m_lost;
    e.p = p & !m_lost;
    e.n = n & !m_lost;
    e.d = one & !m_lost;
    e.s = src_of(m_lost, exp_alt);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int k);
    @(negedge clk);
    bit_vld = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    repeat (k - 1) @(negedge clk);
  endtask

  task automatic zeros(input int k, input string tag);
    for (int i = 0; i < k; i++) send_bit(1'b0, 1'b0, tag);
  endtask

  // Monitor: one result is due one rising edge after each bit.
  logic due = 1'b0;
  always @(posedge clk) due <= bit_vld;

  always @(negedge clk) begin
    if (due) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4", "scoreboard empty", 0, 1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(los == e.l, e.tag, "los", los, e.l);
        check({out_pos, out_neg, out_data} == {e.p, e.n, e.d}, e.tag, "out rails",
              {out_pos, out_neg, out_data}, {e.p, e.n, e.d});
        check(clk_src == e.s, (e.tag == "R9") ? "R9" : "R8", "clk_src", clk_src, e.s);
      end
    end
  end

  // Alternate reference clock: toggles every 3 cycles while enabled.
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (alt_run) alt_ref = ~alt_ref;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    check(los == 1'b1, "R3", "los after reset", los, 1);
    check(clk_src == 2'd2, "R3", "clk_src after reset", clk_src, 2);
    check(alt_active == 1'b0, "R3", "alt_active after reset", alt_active, 0);
    check({out_pos, out_neg, out_data} == 3'b000, "R4", "outputs during loss",
          {out_pos, out_neg, out_data}, 0);

    // R5: dense window clears loss on its 128th bit
    for (int i = 0; i < 128; i++) send_bit(i % 4 == 0, 1'b0, "R5");
    idle(2);
    check(los == 1'b0, "R5", "los after dense window", los, 0);

    // R4: pass-through of rails once the line is healthy
    send_bit(1'b1, 1'b0, "R4");
    send_bit(1'b0, 1'b1, "R4");
    send_bit(1'b0, 1'b0, "R4");
    send_bit(1'b1, 1'b1, "R4");
    idle(2);
    check({out_pos, out_neg, out_data} == 3'b000, "R4", "outputs with no bit",
          {out_pos, out_neg, out_data}, 0);

    // R2: a single one restarts the zero run
    zeros(174, "R2");
    send_bit(1'b0, 1'b1, "R2");
    zeros(174, "R2");
    idle(2);
    check(los == 1'b0, "R2", "los after broken runs", los, 0);

    // R1: 175th consecutive zero declares loss
    zeros(1, "R1");
    idle(2);
    check(los == 1'b1, "R1", "los at 175 zeros", los, 1);

    // R6: 15 ones is not enough
    for (int i = 0; i < 128; i++) send_bit((i % 8 == 0) && (i < 120), 1'b0, "R6");
    idle(2);
    check(los == 1'b1, "R6", "los after 15-one window", los, 1);

    // R6: enough ones but a 100-zero run
    for (int i = 0; i < 128; i++) send_bit(1'b0, i < 20, "R6");
    idle(2);
    check(los == 1'b1, "R6", "los after long-run window", los, 1);

    // R5: exactly 16 ones clears
    for (int i = 0; i < 128; i++) send_bit(i % 8 == 0, 1'b0, "R5");
    idle(2);
    check(los == 1'b0, "R5", "los after 16-one window", los, 0);

    // R5: a 99-zero run is tolerated
    zeros(175, "R1");
    for (int i = 0; i < 128; i++) send_bit((i < 16) || (i == 115), 1'b0, "R5");
    idle(2);
    check(los == 1'b0, "R5", "los after 99-run window", los, 0);

    // R7/R8: alternate reference becomes the source during loss
    alt_run = 1;
    idle(10);
    exp_alt = 1;
    check(alt_active == 1'b1, "R7", "alt_active while toggling", alt_active, 1);
    check(clk_src == 2'd0, "R8", "clk_src healthy", clk_src, 0);
    zeros(175, "R9");
    idle(2);
    check(clk_src == 2'd1, "R8", "clk_src lost with alt", clk_src, 1);

    // R7/R8: alternate stops, centred oscillator takes over
    alt_run = 0;
    idle(80);
    exp_alt = 0;
    check(alt_active == 1'b0, "R7", "alt_active after timeout", alt_active, 0);
    check(clk_src == 2'd2, "R8", "clk_src lost without alt", clk_src, 2);
    check(los == 1'b1, "R9", "los held through idle", los, 1);

    for (int i = 0; i < 128; i++) send_bit(1'b0, i % 2 == 0, "R9");
    idle(2);
    check(clk_src == 2'd0, "R9", "clk_src back to recovered", clk_src, 0);
    check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);

    finish_run();
  end

endmodule